// File: doc/BRIEF.md
# One-time-programmable byte store with mode decoder

This block is a synthesizable behavioural model of a byte-wide one-time-programmable memory together with the logic that decides what it does on each cycle. Three active-low controls steer it: a chip select, a read gate and a program strobe. Two level flags stand in for analog conditions. One flag says that the programming supply is raised. The other says that the high identification voltage is present on address bit 9. The decoder picks one of seven behaviours: normal read, outputs off, standby, program, program check, program blocked, or identification read.

The storage is a small parameterised register file. On reset every bit is set to one, which models the erased state. A program operation can only clear bits, because the new byte is the bitwise AND of the stored byte and the input byte. While the identification flag is set, the data path is replaced by fixed identifier bytes. Each of these bytes carries odd parity in its top bit. The outputs are a byte and an enable meant for an external tri-state driver. Access timing and voltage levels are not modelled.

Top module: `otp_byte_store`

## Requirements
- R1: After reset every stored byte reads back as 0xFF.
- R2: With sel_n=0, rd_n=0, prog_hv=0 and id_hv=0, q_oe is 1 and q carries the byte at the word selected by the low address bits, in the same cycle.
- R3: With sel_n=0 and rd_n=1, q_oe is 0 and q is 0x00, except in program mode, which R5 covers.
- R4: With sel_n=1 and prog_hv=0, the block is in standby: q_oe is 0 and q is 0x00 whatever rd_n is.
- R5: Program mode is prog_hv=1, sel_n=0, rd_n=1, strb_n=0. In this mode q_oe is 0. A write happens on the clock edge that samples strb_n low when the previous edge sampled it high. The new byte is old AND wdata, and it is visible from the next cycle on.
- R6: A single falling strobe writes once. Holding strb_n low for more cycles adds no write, and a 1 in wdata never sets a stored 0 back to 1.
- R7: Program check is prog_hv=1, sel_n=0, rd_n=0, strb_n=1. In this mode q_oe is 1 and q carries the stored byte.
- R8: With prog_hv=1 and sel_n=1, programming is blocked: q_oe is 0 and a falling strobe writes nothing.
- R9: With id_hv=1, prog_hv=0, sel_n=0, rd_n=0 and addr[1]=1, q is 0x1C when addr[0]=0 and 0x01 when addr[0]=1, with q_oe=1.
- R10: With the identification conditions of R9 but addr[1]=0, q is 0x7F for either value of addr[0].
- R11: Every identifier byte has an odd number of ones, and bit 7 is the parity bit over bits 6..0.
- R12: A falling strobe in any mode other than program leaves the array unchanged. This includes prog_hv=1 with sel_n=0, rd_n=0, strb_n=0, which is an undefined combination with outputs off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets every stored bit to one |
| sel_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low output gate |
| strb_n | input | 1 | Active-low program strobe |
| prog_hv | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identification voltage present on address bit 9 |
| addr | input | ADDR_W | Byte address; the low bits select the word, bits 1..0 select the identifier |
| wdata | input | 8 | Byte to program |
| q | output | 8 | Output byte, 0x00 while q_oe is 0 |
| q_oe | output | 1 | Enable for an external tri-state driver |

## Verification
Mode decode, identifier selection and array reads are combinational, so q and q_oe are due in the same cycle as the control and address inputs. A program write lands on the rising edge that closes the first strobe-low cycle, so its effect is due in the cycle after that. The driver changes inputs on the falling clock edge and queues the expected result. The monitor pops and compares it a quarter period later, before the next rising edge. Each write is therefore checked one driver step after the strobe-low step, through a program-check or read access.

// File: rtl/otp_pkg.sv
package otp_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      MODE_STANDBY = 3'd0,
      MODE_BLOCKED = 3'd1,
      MODE_OFF     = 3'd2,
      MODE_READ    = 3'd3,
      MODE_IDENT   = 3'd4,
      MODE_PROGRAM = 3'd5,
      MODE_CHECK   = 3'd6
   } otp_mode_e;

   // identifier payloads, bits 6..0; bit 7 is the odd-parity bit
   localparam logic [6:0] ID_MAKER_LO = 7'h1C;
   localparam logic [6:0] ID_PART_LO  = 7'h01;
   localparam logic [6:0] ID_CONT_LO  = 7'h7F;

   // complete bytes for the variant that stores them whole
   localparam logic [7:0] ID_MAKER_B = 8'h1C;
   localparam logic [7:0] ID_PART_B  = 8'h01;
   localparam logic [7:0] ID_CONT_B  = 8'h7F;

   function automatic logic [7:0] add_odd_parity(input logic [6:0] v);
      return {~(^v), v};
   endfunction

   function automatic logic mode_drives(input otp_mode_e m);
      return (m == MODE_READ) || (m == MODE_IDENT) || (m == MODE_CHECK);
   endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
   import otp_pkg::*;
(
   input  logic      sel_n,
   input  logic      rd_n,
   input  logic      strb_n,
   input  logic      prog_hv,
   input  logic      id_hv,
   output otp_mode_e mode
);

   always_comb begin
      mode = MODE_STANDBY;
      if (sel_n) begin
         mode = prog_hv ? MODE_BLOCKED : MODE_STANDBY;
      end else if (rd_n) begin
         if (prog_hv && !strb_n) begin
            mode = MODE_PROGRAM;
         end else begin
            mode = MODE_OFF;
         end
      end else if (prog_hv) begin
         // strobe low with the gate low is undefined: keep outputs off
         mode = strb_n ? MODE_CHECK : MODE_OFF;
      end else begin
         mode = id_hv ? MODE_IDENT : MODE_READ;
      end
   end

endmodule

// File: rtl/otp_strobe_edge.sv
module otp_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strb_n,
   output logic fall
);

   logic strb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b1;
      end else begin
         strb_q <= strb_n;
      end
   end

   assign fall = strb_q & ~strb_n;

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int WORDS  = 64,
   parameter int WIDTH  = 8,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDTH-1:0] wr_mask,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WIDTH-1:0] rd_data
);

   logic [WORDS-1:0][WIDTH-1:0] cells;

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [WIDTH-1:0] word_q;
      logic             hit;

      assign hit = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '1;
         end else if (hit) begin
            word_q <= word_q & wr_mask;
         end
      end

      assign cells[g] = word_q;
   end

   assign rd_data = cells[rd_idx];

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
   import otp_pkg::*;
#(
   parameter bit GEN_PARITY = 1'b1
) (
   input  logic       a0,
   input  logic       a1,
   output logic [7:0] id_byte
);

   if (GEN_PARITY) begin : g_gen
      logic [6:0] lo;
      always_comb begin
         if (!a1) begin
            lo = ID_CONT_LO;
         end else if (a0) begin
            lo = ID_PART_LO;
         end else begin
            lo = ID_MAKER_LO;
         end
      end
      assign id_byte = add_odd_parity(lo);
   end else begin : g_const
      always_comb begin
         if (!a1) begin
            id_byte = ID_CONT_B;
         end else if (a0) begin
            id_byte = ID_PART_B;
         end else begin
            id_byte = ID_MAKER_B;
         end
      end
   end

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
   import otp_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int WORDS      = 64,
   parameter bit GEN_PARITY = 1'b1,
   localparam int IDX_W     = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_n,
   input  logic              strb_n,
   input  logic              prog_hv,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] q,
   output logic              q_oe
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("otp_byte_store: ADDR_W must be at least 2");
   end
   if (WORDS < 2 || (1 << IDX_W) != WORDS) begin : g_bad_words
      $error("otp_byte_store: WORDS must be a power of two of at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_fit
      $error("otp_byte_store: WORDS exceeds the address range");
   end

   otp_mode_e         mode;
   logic              strb_fall;
   logic              wr_en;
   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] cell_byte;
   logic [BYTE_W-1:0] id_byte;
   logic              unused_hi;

   assign idx       = addr[IDX_W-1:0];
   assign unused_hi = ^addr;

   otp_mode_decode u_dec (
      .sel_n   (sel_n),
      .rd_n    (rd_n),
      .strb_n  (strb_n),
      .prog_hv (prog_hv),
      .id_hv   (id_hv),
      .mode    (mode)
   );

   otp_strobe_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb_n (strb_n),
      .fall   (strb_fall)
   );

   assign wr_en = strb_fall && (mode == MODE_PROGRAM);

   otp_cell_array #(
      .WORDS (WORDS),
      .WIDTH (BYTE_W)
   ) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (idx),
      .wr_mask (wdata),
      .rd_idx  (idx),
      .rd_data (cell_byte)
   );

   otp_id_rom #(
      .GEN_PARITY (GEN_PARITY)
   ) u_id (
      .a0      (addr[0]),
      .a1      (addr[1]),
      .id_byte (id_byte)
   );

   always_comb begin
      q_oe = mode_drives(mode);
      unique case (mode)
         MODE_IDENT:            q = id_byte;
         MODE_READ, MODE_CHECK: q = cell_byte;
         default:               q = '0;
      endcase
   end

endmodule

// File: rtl/otp_byte_store_chk.sv
module otp_byte_store_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n,
   input logic              rd_n,
   input logic              strb_n,
   input logic              prog_hv,
   input logic              id_hv,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        q,
   input logic              q_oe,
   input logic              wr_en
);

   a_r4_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && !prog_hv) |-> (!q_oe && q == 8'h00));

   a_r3_gate_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && rd_n) |-> !q_oe);

   a_r8_blocked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && prog_hv) |-> (!q_oe && !wr_en));

   a_r12_write_only_in_program: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!sel_n && rd_n && prog_hv && !strb_n));

   a_r6_one_write_per_fall: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   a_r11_id_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !rd_n && !prog_hv && id_hv) |-> (q_oe && (^q) == 1'b1));

   a_r10_id_continuation: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !rd_n && !prog_hv && id_hv && !addr[1]) |-> (q == 8'h7F));

   a_r7_check_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !rd_n && prog_hv && strb_n) |-> q_oe);

endmodule

bind otp_byte_store otp_byte_store_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_n   (sel_n),
   .rd_n    (rd_n),
   .strb_n  (strb_n),
   .prog_hv (prog_hv),
   .id_hv   (id_hv),
   .addr    (addr),
   .q       (q),
   .q_oe    (q_oe),
   .wr_en   (wr_en)
);

// File: tb/test_otp_byte_store.sv
module test_otp_byte_store;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sel_n = 1'b1;
   logic              rd_n = 1'b1;
   logic              strb_n = 1'b1;
   logic              prog_hv = 1'b0;
   logic              id_hv = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        wdata = 8'hFF;
   logic [7:0]        q;
   logic              q_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic       en;
      logic [7:0] d;
      string      tag;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_byte_store #(.ADDR_W(ADDR_W)) i_otp_byte_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (sel_n),
      .rd_n    (rd_n),
      .strb_n  (strb_n),
      .prog_hv (prog_hv),
      .id_hv   (id_hv),
      .addr    (addr),
      .wdata   (wdata),
      .q       (q),
      .q_oe    (q_oe)
   );

   // driver: inputs change on the falling edge
   task automatic drive(input logic s, input logic r, input logic p,
                        input logic hv, input logic idv,
                        input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      sel_n = s; rd_n = r; strb_n = p; prog_hv = hv; id_hv = idv;
      addr = a; wdata = d;
   endtask

   task automatic drive_exp(input logic s, input logic r, input logic p,
                            input logic hv, input logic idv,
                            input logic [ADDR_W-1:0] a, input logic [7:0] d,
                            input logic e_en, input logic [7:0] e_d,
                            input string tag);
      exp_t it;
      drive(s, r, p, hv, idv, a, d);
      it.en = e_en; it.d = e_d; it.tag = tag;
      sb.push_back(it);
   endtask

   // program a byte: arm strobe high, then one strobe-low cycle
   task automatic program_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a, d);
      drive_exp(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, d, 1'b0, 8'h00, "R5 outputs off in program");
   endtask

   // monitor: compare a quarter period after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (q_oe !== it.en || q !== it.d) begin
               errors++;
               $display("FAIL %s: got oe=%0b q=%02h, expected oe=%0b q=%02h",
                        it.tag, q_oe, q, it.en, it.d);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD*5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: erased array reads all ones
      drive_exp(0, 0, 1, 0, 0, 10'd0,  8'h00, 1, 8'hFF, "R1 erased word 0");
      drive_exp(0, 0, 1, 0, 0, 10'd5,  8'h00, 1, 8'hFF, "R1 erased word 5");
      drive_exp(0, 0, 1, 0, 0, 10'd63, 8'h00, 1, 8'hFF, "R1 erased word 63");

      // R4 standby, R3 gate high
      drive_exp(1, 0, 1, 0, 0, 10'd5, 8'h00, 0, 8'h00, "R4 standby gate low");
      drive_exp(1, 1, 0, 0, 1, 10'd5, 8'h00, 0, 8'h00, "R4 standby with id flag");
      drive_exp(0, 1, 1, 0, 0, 10'd5, 8'h00, 0, 8'h00, "R3 gate high off");
      drive_exp(0, 1, 1, 1, 0, 10'd5, 8'h00, 0, 8'h00, "R3 gate high strobe high");

      // R5/R7/R2: program and read back
      program_byte(10'd3, 8'hA5);
      drive_exp(0, 0, 1, 1, 0, 10'd3, 8'h00, 1, 8'hA5, "R7 check after program");
      drive_exp(0, 0, 1, 0, 0, 10'd3, 8'h00, 1, 8'hA5, "R2 read after program");
      drive_exp(0, 0, 1, 0, 0, 10'd4, 8'h00, 1, 8'hFF, "R2 neighbour untouched");

      // R6: only clears bits
      program_byte(10'd3, 8'h3C);
      drive_exp(0, 0, 1, 1, 0, 10'd3, 8'h00, 1, 8'h24, "R6 AND with stored");
      program_byte(10'd3, 8'hFF);
      drive_exp(0, 0, 1, 1, 0, 10'd3, 8'h00, 1, 8'h24, "R6 ones do not restore");

      // R6: strobe held low writes once
      drive(0, 1, 1, 1, 0, 10'd7, 8'hF0);
      drive(0, 1, 0, 1, 0, 10'd7, 8'hF0);
      drive(0, 1, 0, 1, 0, 10'd7, 8'h0F);
      drive(0, 1, 0, 1, 0, 10'd7, 8'h00);
      drive_exp(0, 0, 1, 1, 0, 10'd7, 8'h00, 1, 8'hF0, "R6 held strobe single write");

      // R8: blocked
      drive(1, 1, 1, 1, 0, 10'd9, 8'h00);
      drive_exp(1, 1, 0, 1, 0, 10'd9, 8'h00, 0, 8'h00, "R8 blocked outputs off");
      drive_exp(1, 0, 0, 1, 0, 10'd9, 8'h00, 0, 8'h00, "R8 blocked gate low off");
      drive_exp(0, 0, 1, 1, 0, 10'd9, 8'h00, 1, 8'hFF, "R8 no write while blocked");

      // R12: strobe falls outside program mode
      drive(0, 0, 1, 0, 0, 10'd10, 8'h00);
      drive_exp(0, 0, 0, 0, 0, 10'd10, 8'h00, 1, 8'hFF, "R12 fall in read");
      drive(0, 1, 1, 0, 0, 10'd11, 8'h00);
      drive(0, 1, 0, 0, 0, 10'd11, 8'h00);
      drive(0, 0, 1, 1, 0, 10'd12, 8'h00);
      drive_exp(0, 0, 0, 1, 0, 10'd12, 8'h00, 0, 8'h00, "R12 undefined combo off");
      drive_exp(0, 0, 1, 0, 0, 10'd10, 8'h00, 1, 8'hFF, "R12 word 10 unchanged");
      drive_exp(0, 0, 1, 0, 0, 10'd11, 8'h00, 1, 8'hFF, "R12 word 11 unchanged");
      drive_exp(0, 0, 1, 1, 0, 10'd12, 8'h00, 1, 8'hFF, "R12 word 12 unchanged");

      // R9/R10/R11: identification bytes (other address bits high)
      drive_exp(0, 0, 1, 0, 1, 10'h3FE, 8'h00, 1, 8'h1C, "R9 maker byte");
      drive_exp(0, 0, 1, 0, 1, 10'h3FF, 8'h00, 1, 8'h01, "R9 part byte");
      drive_exp(0, 0, 1, 0, 1, 10'h3FC, 8'h00, 1, 8'h7F, "R10 continuation a0=0");
      drive_exp(0, 0, 0, 0, 1, 10'h3FD, 8'h00, 1, 8'h7F, "R10 continuation a0=1");
      drive_exp(0, 0, 1, 0, 1, 10'h002, 8'h00, 1, 8'h1C, "R11 maker parity bit7=0");
      drive_exp(0, 1, 1, 0, 1, 10'h3FE, 8'h00, 0, 8'h00, "R3 id flag with gate high");

      // back to plain read of a programmed word
      drive_exp(0, 0, 1, 0, 0, 10'd7, 8'h00, 1, 8'hF0, "R2 read word 7");
      drive(1, 1, 1, 0, 0, 10'd0, 8'h00);
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule